// File: doc/BRIEF.md
# Reset and Watchdog Supervisor

This block produces the reset for a processor. It takes three inputs: a digital flag from an external supply comparator that says whether the supply is above its threshold, a manual-reset pin that is active low, and a watchdog strobe that the software toggles. Any one of these can start a reset. Once the last cause has cleared, the reset is held for a fixed stretch of prescaled ticks before it is released.

The watchdog counts ticks only while reset is released. Either edge of the strobe restarts it from zero. If no edge arrives for the watchdog period, it fires, and that causes one stretched reset pulse. Nothing can switch the watchdog off. If the strobe never moves, the pulses repeat with a period equal to the watchdog time plus the stretch time.

All intervals are counted in ticks from a free-running prescaler. The prescaler divides the clock by a parameter. Both periods are parameters given in tick counts, with defaults of 200 and 1600 ticks; at a 1 ms tick these are 200 ms and 1.6 s. The strobe and the manual-reset pin pass through two-flop synchronisers. The supply flag is taken as already synchronous to the clock.

Top module: `reset_supervisor`

## Requirements
- R1: While the block's own reset `rst_ni` is low, and directly after it is released, `rst_no` is 0. It stays 0 until the stretch has run.
- R2: A 0 on `supply_ok_i` at a clock edge makes `rst_no` 0 after that edge and restarts the stretch count from zero.
- R3: A 0 on `mr_ni` asserts reset once it has passed the two-flop synchroniser. Reset stays asserted while the pin is low.
- R4: After the last assert cause clears, reset is released on the clock edge of the `RST_TICKS`-th tick that follows.
- R5: If the watchdog counts `WD_TICKS` ticks with reset released and no strobe edge, it causes exactly one stretched reset pulse.
- R6: A rising edge or a falling edge of the synchronised `wdi_i` clears the watchdog count.
- R7: While reset is asserted, the watchdog count is held at zero.
- R8: With `wdi_i` held constant, successive releases of `rst_no` are exactly `(WD_TICKS+RST_TICKS)*TICK_DIV` clock cycles apart. No input stops this.
- R9: `rst_o` is always the exact inverse of `rst_no`.
- R10: A tick occurs once every `TICK_DIV` clock cycles and never in two adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset of the block, active low |
| supply_ok_i | input | 1 | 1 when the supply is above the reset threshold |
| mr_ni | input | 1 | Manual reset request, active low, asynchronous |
| wdi_i | input | 1 | Watchdog strobe, asynchronous |
| rst_no | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |

## Verification
The bench tries several input patterns in turn:
- a steady strobe, to show that regular edges of either polarity keep reset released;
- a short supply dip and a manual-reset hold, to show that the stretch restarts from the last cause rather than the first;
- a strobe that toggles during reset, to separate a watchdog that is frozen while reset is held from one that keeps counting;
- a strobe held constant, to measure the pulse period, which tells a watchdog that counts from the release apart from one that counts from the fire or never stops.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int unsigned DEF_TICK_DIV  = 50000;
  localparam int unsigned DEF_RST_TICKS = 200;
  localparam int unsigned DEF_WD_TICKS  = 1600;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned WIDTH     = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sup_tick.sv
module sup_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = $clog2(DIV + 1);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  if (DIV > 1) begin : g_spacing
    assert_tick_spacing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  input  logic tick_i,
  output logic hold_o
);
  localparam int unsigned W = $clog2(TICKS + 1);
  localparam logic [W-1:0] LAST = W'(TICKS - 1);

  logic [W-1:0] cnt_q;
  logic         hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (cause_i) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q && tick_i) begin
      if (cnt_q == LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;

  assert_cause_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i |=> hold_q);
  assert_release_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> ($past(tick_i) && !$past(cause_i)));
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned TICKS = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic edge_i,
  input  logic tick_i,
  output logic fire_o
);
  localparam int unsigned W = $clog2(TICKS + 1);
  localparam logic [W-1:0] LAST = W'(TICKS - 1);

  logic [W-1:0] cnt_q;
  logic         fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (hold_i || edge_i) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (tick_i && cnt_q == LAST) begin
      cnt_q  <= '0;
      fire_q <= 1'b1;
    end else begin
      fire_q <= 1'b0;
      if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = fire_q;

  assert_edge_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> (cnt_q == '0 && !fire_q));
  assert_frozen_in_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
  assert_single_fire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned TICK_DIV  = DEF_TICK_DIV,
  parameter int unsigned RST_TICKS = DEF_RST_TICKS,
  parameter int unsigned WD_TICKS  = DEF_WD_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic mr_ni,
  input  logic wdi_i,
  output logic rst_no,
  output logic rst_o
);
  logic       tick;
  logic [1:0] sync_q;
  logic       wdi_s, mr_s, wdi_prev_q, wdi_edge;
  logic       wd_fire, hold, cause;

  sup_tick #(.DIV(TICK_DIV)) i_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  // bit 1: manual reset (idles high), bit 0: strobe
  sup_sync #(.WIDTH(2), .RST_VAL(2'b10)) i_sync (
    .clk_i, .rst_ni, .d_i({mr_ni, wdi_i}), .q_o(sync_q)
  );
  assign {mr_s, wdi_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdi_prev_q <= 1'b0;
    else         wdi_prev_q <= wdi_s;
  end
  assign wdi_edge = wdi_s ^ wdi_prev_q;

  assign cause = !supply_ok_i || !mr_s || wd_fire;

  sup_stretch #(.TICKS(RST_TICKS)) i_stretch (
    .clk_i, .rst_ni, .cause_i(cause), .tick_i(tick), .hold_o(hold)
  );

  sup_watchdog #(.TICKS(WD_TICKS)) i_wdog (
    .clk_i, .rst_ni, .hold_i(hold), .edge_i(wdi_edge), .tick_i(tick), .fire_o(wd_fire)
  );

  assign rst_no = !hold;
  assign rst_o  = hold;

  assert_supply_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !rst_no);
  assert_fire_resets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_fire |=> rst_o);
endmodule

// File: tb/test_reset_supervisor.sv
module test_reset_supervisor;
  localparam int DIV = 4;
  localparam int RT  = 5;
  localparam int WT  = 12;

  logic clk = 0, rst_n = 0, sup = 1, mr_n = 1, wdi = 0;
  logic rst_no, rst_o;
  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  reset_supervisor #(.TICK_DIV(DIV), .RST_TICKS(RT), .WD_TICKS(WT)) i_reset_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .mr_ni(mr_n), .wdi_i(wdi),
    .rst_no(rst_no), .rst_o(rst_o)
  );

  // behavioural reference
  int m_pc, m_rc, m_wc;
  bit m_rst, m_fire, m_w1, m_w2, m_wp, m_m1, m_m2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_rc = 0; m_wc = 0; m_rst = 1; m_fire = 0;
      m_w1 = 0; m_w2 = 0; m_wp = 0; m_m1 = 1; m_m2 = 1;
    end else begin
      bit t, e, c, n_rst, n_f;
      int n_rc, n_wc;
      t = (m_pc == DIV - 1);
      e = m_w2 ^ m_wp;
      c = !sup || !m_m2 || m_fire;
      n_rst = m_rst; n_rc = m_rc;
      if (c) begin n_rst = 1; n_rc = 0; end
      else if (m_rst && t) begin
        if (m_rc == RT - 1) begin n_rst = 0; n_rc = 0; end
        else n_rc = m_rc + 1;
      end
      if (m_rst || e) begin n_wc = 0; n_f = 0; end
      else if (t && m_wc == WT - 1) begin n_wc = 0; n_f = 1; end
      else begin n_f = 0; n_wc = t ? m_wc + 1 : m_wc; end
      m_wp = m_w2; m_w2 = m_w1; m_w1 = wdi;
      m_m2 = m_m1; m_m1 = mr_n;
      m_pc = (m_pc + 1) % DIV;
      m_rst = n_rst; m_rc = n_rc; m_wc = n_wc; m_fire = n_f;
    end
  end

  always @(posedge clk) cyc++;

  task automatic check(string r, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", r, cyc, act, exp);
    end
  endtask

  // per-cycle comparison, sampled away from the active edge
  always @(negedge clk) begin
    check(tag, rst_no, !m_rst);
    check("R9", rst_o, !rst_no);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog_timer
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int t0, t1;
    step(3);
    check("R1", rst_no, 1'b0);
    rst_n = 1;
    step(2);
    check("R1", rst_no, 1'b0);
    // R4: released after the stretch
    tag = "R4";
    step(RT * DIV + 4);
    check("R4", rst_no, 1'b1);
    // R6: both edge polarities keep the watchdog quiet
    tag = "R6";
    for (int i = 0; i < 12; i++) begin wdi = ~wdi; step(20); end
    check("R6", rst_no, 1'b1);
    // R2: supply dip
    tag = "R2";
    sup = 0; step(1); check("R2", rst_no, 1'b0);
    step(2); sup = 1;
    step(RT * DIV - 6); check("R2", rst_no, 1'b0);
    step(10); check("R2", rst_no, 1'b1);
    // R3: manual reset
    tag = "R3";
    wdi = ~wdi; mr_n = 0; step(3); check("R3", rst_no, 1'b0);
    step(30); check("R3", rst_no, 1'b0);
    // R7: strobe moving while reset held
    tag = "R7";
    for (int i = 0; i < 4; i++) begin wdi = ~wdi; step(5); end
    mr_n = 1;
    step(RT * DIV + 6); check("R7", rst_no, 1'b1);
    // R5/R8: strobe held constant
    tag = "R5";
    step(WT * DIV + 4); check("R5", rst_no, 1'b0);
    tag = "R8";
    @(posedge rst_no); t0 = cyc;
    @(posedge rst_no); t1 = cyc;
    checks++;
    if (t1 - t0 != (WT + RT) * DIV) begin
      fails++;
      $display("FAIL R8 period actual %0d expected %0d", t1 - t0, (WT + RT) * DIV);
    end
    step(200);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule